// File: doc/BRIEF.md
# Two-Phase Channel Multiplexing Stage

The stage merges three valid/ready input streams into one output stream that strictly alternates between two kinds of result. A one-bit phase register decides which inputs may be taken. In the first phase only stream A is accepted, and the stage emits the increment of its value. In the second phase streams B and C are taken in the same cycle, combined by XOR, and the result is rotated left by one bit before it is emitted. Each accepted input group produces exactly one output word, and the phase then flips.

Stream B is deliberately paired with C instead of with A. As a result no operand has to be kept from one iteration to the next. The only storage is the phase bit and one registered output word. Results go into that output buffer in the same cycle that the inputs are accepted. The buffer presents them on X until the consumer takes them. A new result can be loaded in the same cycle that the old one leaves, so with no stalls there is one output per cycle.

Top module: `mux_stage`

## Requirements
- R1: While rst_ni is low, x_valid_o, a_ready_o, b_ready_o and c_ready_o are all 0. After reset is released, the first output is always an A-phase result.
- R2: In the A phase, b_ready_o and c_ready_o stay 0 whatever b_valid_i and c_valid_i do. No output is produced unless A is accepted.
- R3: An accepted A value a gives x_data_o = (a + 1) mod 2^DATA_W in the next cycle.
- R4: In the BC phase, B and C are accepted only together, in a cycle where both valids are 1 and the buffer can take a result. If only one of them is valid, neither ready is raised.
- R5: Accepted values b and c give x_data_o = rotate-left-by-one(b XOR c) in the next cycle. Bit DATA_W-1 moves to bit 0.
- R6: The phase changes only when a result is loaded. The output sequence is A, BC, A, BC, … and no input value is lost or duplicated.
- R7: While x_valid_o is 1 and x_ready_i is 0, x_valid_o and x_data_o keep their values in the next cycle.
- R8: While the buffer holds a result that is not being taken, no input ready is asserted.
- R9: When x_ready_i is held at 1 and the needed inputs are valid, a new result appears on X every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_valid_i | input | 1 | A stream valid |
| a_data_i | input | DATA_W | A stream data |
| a_ready_o | output | 1 | A stream ready |
| b_valid_i | input | 1 | B stream valid |
| b_data_i | input | DATA_W | B stream data |
| b_ready_o | output | 1 | B stream ready |
| c_valid_i | input | 1 | C stream valid |
| c_data_i | input | DATA_W | C stream data |
| c_ready_o | output | 1 | C stream ready |
| x_valid_o | output | 1 | Output stream valid |
| x_data_o | output | DATA_W | Output stream data |
| x_ready_i | input | 1 | Output stream ready from the consumer |

## Verification
The assertions do not require a producer to hold valid until its transfer completes. They check only relations between the stage's own readies, the output buffer and the phase. The bench's producers take this freedom: each cycle they randomly drop and raise their valids, and B and C stall independently. In each cycle every input stays constant from the falling edge onward, so a ready that depends on the B and C valids is settled when it is sampled.

// File: rtl/mux_stage_pkg.sv
package mux_stage_pkg;
  localparam int unsigned DEF_DATA_W = 8;

  typedef enum logic {
    PH_A  = 1'b0,
    PH_BC = 1'b1
  } phase_e;
endpackage

// File: rtl/mux_stage_alu.sv
module mux_stage_alu #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              sel_bc_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] inc_a;
  logic [DATA_W-1:0] mix_d;
  logic [DATA_W-1:0] rot_d;

  assign inc_a = a_i + {{(DATA_W-1){1'b0}}, 1'b1};
  assign mix_d = b_i ^ c_i;

  // rotate left by one, msb wraps to bit 0
  generate
    if (DATA_W == 1) begin : g_rot1
      assign rot_d = mix_d;
    end else begin : g_rotn
      assign rot_d = {mix_d[DATA_W-2:0], mix_d[DATA_W-1]};
    end
  endgenerate

  assign res_o = sel_bc_i ? rot_d : inc_a;
endmodule

// File: rtl/mux_stage_ctrl.sv
module mux_stage_ctrl
  import mux_stage_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   a_valid_i,
  input  logic   b_valid_i,
  input  logic   c_valid_i,
  input  logic   buf_free_i,
  output logic   a_ready_o,
  output logic   b_ready_o,
  output logic   c_ready_o,
  output logic   load_o,
  output logic   sel_bc_o,
  output phase_e phase_o
);
  phase_e phase_q;
  logic   a_go;
  logic   bc_go;

  assign a_go  = rst_ni && (phase_q == PH_A) && buf_free_i;
  // B and C only move as a pair
  assign bc_go = rst_ni && (phase_q == PH_BC) && buf_free_i && b_valid_i && c_valid_i;

  assign a_ready_o = a_go;
  assign b_ready_o = bc_go;
  assign c_ready_o = bc_go;
  assign load_o    = (a_go && a_valid_i) || bc_go;
  assign sel_bc_o  = (phase_q == PH_BC);
  assign phase_o   = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_A;
    end else if (load_o) begin
      phase_q <= (phase_q == PH_A) ? PH_BC : PH_A;
    end
  end
endmodule

// File: rtl/mux_stage_obuf.sv
module mux_stage_obuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              x_ready_i,
  output logic              free_o,
  output logic              x_valid_o,
  output logic [DATA_W-1:0] x_data_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  // free when empty or draining this cycle
  assign free_o    = !valid_q || x_ready_i;
  assign x_valid_o = valid_q;
  assign x_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= din_i;
    end else if (x_ready_i) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mux_stage.sv
module mux_stage
  import mux_stage_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_valid_i,
  input  logic [DATA_W-1:0] a_data_i,
  output logic              a_ready_o,
  input  logic              b_valid_i,
  input  logic [DATA_W-1:0] b_data_i,
  output logic              b_ready_o,
  input  logic              c_valid_i,
  input  logic [DATA_W-1:0] c_data_i,
  output logic              c_ready_o,
  output logic              x_valid_o,
  output logic [DATA_W-1:0] x_data_o,
  input  logic              x_ready_i
);
  logic              buf_free;
  logic              load;
  logic              sel_bc;
  phase_e            phase;
  logic [DATA_W-1:0] res;

  mux_stage_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_valid_i (a_valid_i),
    .b_valid_i (b_valid_i),
    .c_valid_i (c_valid_i),
    .buf_free_i(buf_free),
    .a_ready_o (a_ready_o),
    .b_ready_o (b_ready_o),
    .c_ready_o (c_ready_o),
    .load_o    (load),
    .sel_bc_o  (sel_bc),
    .phase_o   (phase)
  );

  mux_stage_alu #(.DATA_W(DATA_W)) u_alu (
    .sel_bc_i(sel_bc),
    .a_i     (a_data_i),
    .b_i     (b_data_i),
    .c_i     (c_data_i),
    .res_o   (res)
  );

  mux_stage_obuf #(.DATA_W(DATA_W)) u_obuf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .din_i    (res),
    .x_ready_i(x_ready_i),
    .free_o   (buf_free),
    .x_valid_o(x_valid_o),
    .x_data_o (x_data_o)
  );
endmodule

// File: rtl/mux_stage_chk.sv
module mux_stage_chk
  import mux_stage_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a_valid_i,
  input logic [DATA_W-1:0] a_data_i,
  input logic              a_ready_o,
  input logic              b_valid_i,
  input logic              b_ready_o,
  input logic              c_valid_i,
  input logic              c_ready_o,
  input logic              x_valid_o,
  input logic [DATA_W-1:0] x_data_o,
  input logic              x_ready_i,
  input phase_e            phase
);
  logic [DATA_W-1:0] a_plus;
  assign a_plus = a_data_i + {{(DATA_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (!rst_ni) begin
      a_r1_quiet_in_reset: assert (!a_ready_o && !b_ready_o && !c_ready_o);
    end
  end

  a_r2_no_bc_in_a_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_ready_o || c_ready_o) |-> !a_ready_o);

  a_r4_pair_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_ready_o || c_ready_o) |-> (b_valid_i && c_valid_i && b_ready_o && c_ready_o));

  a_r3_inc_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_valid_i && a_ready_o) |=> (x_valid_o && x_data_o == $past(a_plus)));

  a_r6_flip_after_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_valid_i && a_ready_o) |=> (phase == PH_BC));

  a_r6_flip_after_bc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_valid_i && b_ready_o) |=> (phase == PH_A));

  a_r7_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_valid_o && !x_ready_i) |=> (x_valid_o && $stable(x_data_o)));

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_valid_o && !x_ready_i) |-> (!a_ready_o && !b_ready_o && !c_ready_o));
endmodule

bind mux_stage mux_stage_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_mux_stage.sv
module tb_mux_stage;
  localparam int unsigned W = 8;
  localparam int unsigned NV = 8;

  // {a, b, c, expected inc(a), expected rotl(b^c)}
  localparam logic [39:0] VEC [NV] = '{
    {8'h00, 8'h0F, 8'hF0, 8'h01, 8'hFF},
    {8'hFF, 8'h80, 8'h00, 8'h00, 8'h01},
    {8'h7F, 8'hAA, 8'h00, 8'h80, 8'h55},
    {8'h12, 8'h3C, 8'h0F, 8'h13, 8'h66},
    {8'h80, 8'hC0, 8'h40, 8'h81, 8'h01},
    {8'hFE, 8'h01, 8'h01, 8'hFF, 8'h00},
    {8'h5A, 8'h96, 8'h00, 8'h5B, 8'h2D},
    {8'h33, 8'h40, 8'h00, 8'h34, 8'h80}
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         a_valid = 1'b0, b_valid = 1'b0, c_valid = 1'b0, x_ready = 1'b0;
  logic [W-1:0] a_data = '0, b_data = '0, c_data = '0;
  logic         a_ready, b_ready, c_ready, x_valid;
  logic [W-1:0] x_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mux_stage #(.DATA_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_valid_i(a_valid), .a_data_i(a_data), .a_ready_o(a_ready),
    .b_valid_i(b_valid), .b_data_i(b_data), .b_ready_o(b_ready),
    .c_valid_i(c_valid), .c_data_i(c_data), .c_ready_o(c_ready),
    .x_valid_o(x_valid), .x_data_o(x_data), .x_ready_i(x_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    // R1: reset state
    #3;
    chk(!x_valid, "R1 x_valid in reset", int'(x_valid), 0);
    chk(!a_ready && !b_ready && !c_ready, "R1 readies in reset",
        int'({a_ready, b_ready, c_ready}), 0);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;

    // R2: B/C valid in A phase are ignored
    b_valid = 1'b1; b_data = 8'h11; c_valid = 1'b1; c_data = 8'h22; x_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk(!b_ready && !c_ready, "R2 no bc ready in A phase", int'({b_ready, c_ready}), 0);
      chk(!x_valid, "R2 no output without A", int'(x_valid), 0);
    end
    b_valid = 1'b0; c_valid = 1'b0;

    // R3: one A transfer
    @(negedge clk); a_valid = 1'b1; a_data = 8'h10;
    @(negedge clk); a_valid = 1'b0;
    chk(x_valid && x_data == 8'h11, "R3 inc result", int'(x_data), 'h11);

    // R4: B alone is not accepted in BC phase
    b_valid = 1'b1; b_data = 8'h81;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(!b_ready && !c_ready, "R4 B alone not accepted", int'({b_ready, c_ready}), 0);
    end
    c_valid = 1'b1; c_data = 8'h01; #1;
    chk(b_ready && c_ready, "R4 pair accepted", int'({b_ready, c_ready}), 3);
    // R5: (0x81^0x01)=0x80 -> rotl = 0x01
    @(negedge clk); b_valid = 1'b0; c_valid = 1'b0;
    chk(x_valid && x_data == 8'h01, "R5 rotl xor result", int'(x_data), 1);
    @(negedge clk);

    // R6/R7/R8: table walk under random stalls
    fork
      begin : prod_a
        int i = 0;
        while (i < NV) begin
          @(negedge clk);
          a_valid = ($urandom % 3) != 0; a_data = VEC[i][39:32];
          #1; if (a_valid && a_ready) i++;
        end
        @(negedge clk); a_valid = 1'b0;
      end
      begin : prod_b
        int i = 0;
        while (i < NV) begin
          @(negedge clk);
          b_valid = ($urandom % 3) != 0; b_data = VEC[i][31:24];
          #1; if (b_valid && b_ready) i++;
        end
        @(negedge clk); b_valid = 1'b0;
      end
      begin : prod_c
        int i = 0;
        while (i < NV) begin
          @(negedge clk);
          c_valid = ($urandom % 2) != 0; c_data = VEC[i][23:16];
          #1; if (c_valid && c_ready) i++;
        end
        @(negedge clk); c_valid = 1'b0;
      end
      begin : cons_x
        int o = 0;
        bit held = 1'b0;
        logic [W-1:0] held_d = '0;
        while (o < 2 * NV) begin
          @(negedge clk);
          if (held) chk(x_valid && x_data == held_d, "R7 stalled output stable",
                        int'(x_data), int'(held_d));
          if (held) chk(!a_ready && !b_ready, "R8 no accept while full",
                        int'({a_ready, b_ready}), 0);
          x_ready = ($urandom % 2) != 0;
          #1;
          held = x_valid && !x_ready; held_d = x_data;
          if (x_valid && x_ready) begin
            logic [W-1:0] e;
            e = (o % 2 == 0) ? VEC[o/2][15:8] : VEC[o/2][7:0];
            chk(x_data == e, (o % 2 == 0) ? "R6 R3 A-phase word" : "R6 R5 BC-phase word",
                int'(x_data), int'(e));
            o++;
          end
        end
      end
    join

    // R9: full rate with consumer always ready
    @(negedge clk);
    x_ready = 1'b1;
    a_valid = 1'b1; a_data = 8'h20;
    b_valid = 1'b1; b_data = 8'h01;
    c_valid = 1'b1; c_data = 8'h02;
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] e;
      @(negedge clk);
      e = (k % 2 == 0) ? 8'h21 : 8'h06;
      chk(x_valid && x_data == e, "R9 one result per cycle", int'(x_data), int'(e));
    end

    // R1: reset mid-stream restarts in A phase
    @(negedge clk); x_ready = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b0; #1;
    chk(!x_valid, "R1 reset empties buffer", int'(x_valid), 0);
    chk(!a_ready && !b_ready, "R1 readies low in reset", int'({a_ready, b_ready}), 0);
    @(negedge clk); rst_ni = 1'b1; x_ready = 1'b1; a_data = 8'h44;
    @(negedge clk);
    chk(x_valid && x_data == 8'h45, "R1 first word after reset is A phase", int'(x_data), 'h45);
    a_valid = 1'b0; b_valid = 1'b0; c_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    summary();
  end
endmodule